// File: doc/BRIEF.md
# Memory region lookup unit

This block decodes a 32-bit request address against a small table of memory regions. Each region is described by an inclusive start address and an exclusive end address. A lookup names the access size, either a single byte or a 32-bit word. It returns one of three results:

- the index of the one region that holds the whole access, together with the offset of the address from that region's start;
- a fault, when no region holds the access;
- an error, when more than one region holds it. Overlapping regions are not resolved by priority.

Multi-byte data is little-endian, so a word access covers the address and the three bytes above it.

Regions are set up through a command port. A region is defined either with an explicit end, or with only a start. In the second case the end is derived by rounding start + 1 up to the next 16 MB boundary. Region 0 serves as the code region, region 1 as the data/heap region and region 2 as the stack region. Two grow commands raise the end of the code region and of the data region. A grow never shrinks a region.

Lookups pass through a three-state controller:

- **IDLE** (`req_ready` high) moves to **CHECK** on an accepted request. The address and size are captured on that transition.
- **CHECK** moves to **RESP**. The comparison against every region is made and registered on that transition.
- **RESP** holds `resp_valid` for one cycle and then returns to **IDLE**.

Top module: `region_lookup`

## Requirements
- R1: A byte access (`req_word`=0) matches a defined region when start <= addr < end.
- R2: A word access (`req_word`=1) matches a defined region only when addr >= start and addr + 4 <= end, compared at 33 bits, so addresses near 0xFFFFFFFF never wrap into a match.
- R3: When exactly one region matches, the response has `resp_hit`=1, `resp_region` = that region's index, and `resp_offset` = addr - start.
- R4: When no region matches, the response has `resp_fault`=1. Undefined regions never match.
- R5: When two or more regions match, the response has `resp_multi`=1, with `resp_region`=0 and `resp_offset`=0. The same zero values apply on a fault.
- R6: `cmd_op`=1 defines region `cmd_idx` with start `cmd_start` and end `cmd_end`.
- R7: `cmd_op`=2 defines region `cmd_idx` with start `cmd_start` and end ((cmd_start + 1) rounded up to a multiple of 0x1000000). The end is held at 33 bits, so it can equal 2^32.
- R8: `cmd_op`=3 grows region 0 and `cmd_op`=4 grows region 1. The end is set to `cmd_end` unless `cmd_end` is below the current end, in which case the command is ignored. A grow of an undefined region is also ignored.
- R9: `cmd_op`=5 makes region `cmd_idx` undefined. `cmd_op` values 0, 6 and 7 do nothing.
- R10: A request is accepted only when `req_valid` and `req_ready` are both high. `resp_valid` rises after the second clock edge following acceptance and lasts exactly one cycle. `req_ready` is low from acceptance until the cycle after the response, and requests in that window are ignored.
- R11: After reset every region is undefined, `req_ready`=1 and `resp_valid`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_op | input | 3 | Table command: 0 none, 1 define, 2 define with derived end, 3 grow code, 4 grow data, 5 clear |
| cmd_idx | input | $clog2(NREG) | Region selected by define/clear |
| cmd_start | input | AW | Start address for define commands |
| cmd_end | input | AW | End address for define and grow commands |
| req_valid | input | 1 | Lookup request |
| req_ready | output | 1 | Controller is in IDLE and accepts a request |
| req_addr | input | AW | Lookup address |
| req_word | input | 1 | 1 = 32-bit access, 0 = byte access |
| resp_valid | output | 1 | Lookup result present (RESP state) |
| resp_hit | output | 1 | Exactly one region matched |
| resp_fault | output | 1 | No region matched |
| resp_multi | output | 1 | More than one region matched |
| resp_region | output | $clog2(NREG) | Index of the matching region |
| resp_offset | output | AW | Address minus region start |

## Verification
The bench sweeps a list of addresses around every defined region's edges, for both access sizes: start - 1, start, start + 1, end - 5 through end - 3, end - 1 and end. A design that tested only the first byte of a word would hit at end - 3 where a fault is due. An exclusive/inclusive slip would show up at start - 1 or at end. The sweeps are repeated across several table configurations:

- an overlapping pair, where a priority encoder would report a hit instead of the error;
- a region whose derived end is 2^32, which a 32-bit end register would wrap to zero;
- a region ending at 0xFFFFFFFF, where a 32-bit addr + 4 would wrap and falsely match.

Grow commands below the current end, clears, and requests driven while the controller is busy are each followed by lookups. These show that the table and the captured address were left untouched.

// File: rtl/region_pkg.sv
package region_pkg;

    typedef enum logic [2:0] {
        CMD_NOP         = 3'd0,
        CMD_DEFINE      = 3'd1,
        CMD_DEFINE_AUTO = 3'd2,
        CMD_GROW_CODE   = 3'd3,
        CMD_GROW_DATA   = 3'd4,
        CMD_CLEAR       = 3'd5
    } cmd_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_CHECK = 2'd1,
        ST_RESP  = 2'd2
    } state_e;

    localparam int CODE_REGION  = 0;
    localparam int DATA_REGION  = 1;
    localparam int STACK_REGION = 2;

endpackage

// File: rtl/region_table.sv
module region_table
    import region_pkg::*;
#(
    parameter int NREG       = 4,
    parameter int AW         = 32,
    parameter int ALIGN_LOG2 = 24,
    localparam int IW        = $clog2(NREG)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [2:0]             cmd_op,
    input  logic [IW-1:0]          cmd_idx,
    input  logic [AW-1:0]          cmd_start,
    input  logic [AW-1:0]          cmd_end,
    output logic [NREG-1:0]        tbl_valid,
    output logic [NREG-1:0][AW-1:0] tbl_start,
    output logic [NREG-1:0][AW:0]  tbl_end
);

    localparam logic [AW:0] ALIGN_V = (AW+1)'(1) << ALIGN_LOG2;
    localparam logic [AW:0] ALIGN_M = ALIGN_V - (AW+1)'(1);

    cmd_e        op;
    logic [AW:0] wide_end;
    logic [AW:0] auto_sum;
    logic [AW:0] auto_end;

    always_comb begin
        op       = cmd_e'(cmd_op);
        wide_end = {1'b0, cmd_end};
        // (start + 1 + align - 1) with the low bits cleared
        auto_sum = {1'b0, cmd_start} + ALIGN_V;
        auto_end = auto_sum & ~ALIGN_M;
    end

    for (genvar g = 0; g < NREG; g++) begin : g_slot
        localparam bit IS_CODE = (g == CODE_REGION);
        localparam bit IS_DATA = (g == DATA_REGION);
        logic sel;
        logic grow_sel;

        always_comb begin
            sel      = (cmd_idx == IW'(g));
            grow_sel = (IS_CODE && op == CMD_GROW_CODE) ||
                       (IS_DATA && op == CMD_GROW_DATA);
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                tbl_valid[g] <= 1'b0;
                tbl_start[g] <= '0;
                tbl_end[g]   <= '0;
            end else begin
                if (grow_sel) begin
                    if (tbl_valid[g] && wide_end >= tbl_end[g])
                        tbl_end[g] <= wide_end;
                end else if (sel) begin
                    case (op)
                        CMD_DEFINE: begin
                            tbl_valid[g] <= 1'b1;
                            tbl_start[g] <= cmd_start;
                            tbl_end[g]   <= wide_end;
                        end
                        CMD_DEFINE_AUTO: begin
                            tbl_valid[g] <= 1'b1;
                            tbl_start[g] <= cmd_start;
                            tbl_end[g]   <= auto_end;
                        end
                        CMD_CLEAR: tbl_valid[g] <= 1'b0;
                        default: ;
                    endcase
                end
            end
        end
    end

endmodule

// File: rtl/region_match.sv
module region_match #(
    parameter int NREG = 4,
    parameter int AW   = 32,
    localparam int IW  = $clog2(NREG),
    localparam int CW  = $clog2(NREG + 1)
) (
    input  logic [AW-1:0]           addr,
    input  logic                    word,
    input  logic [NREG-1:0]         tbl_valid,
    input  logic [NREG-1:0][AW-1:0] tbl_start,
    input  logic [NREG-1:0][AW:0]   tbl_end,
    output logic                    m_hit,
    output logic                    m_fault,
    output logic                    m_multi,
    output logic [IW-1:0]           m_idx,
    output logic [AW-1:0]           m_offset
);

    logic [NREG-1:0] hit_vec;
    logic [AW:0]     last_byte;

    // one past the last byte touched, at 33 bits so it cannot wrap
    always_comb last_byte = {1'b0, addr} + (word ? (AW+1)'(4) : (AW+1)'(1));

    for (genvar g = 0; g < NREG; g++) begin : g_cmp
        always_comb hit_vec[g] = tbl_valid[g] &&
                                 (addr >= tbl_start[g]) &&
                                 (last_byte <= tbl_end[g]);
    end

    logic [CW-1:0] count;
    logic [IW-1:0] found;

    always_comb begin
        count = '0;
        found = '0;
        for (int i = 0; i < NREG; i++) begin
            if (hit_vec[i]) begin
                count = count + CW'(1);
                found = IW'(i);
            end
        end
        m_hit    = (count == CW'(1));
        m_fault  = (count == '0);
        m_multi  = (count > CW'(1));
        m_idx    = m_hit ? found : '0;
        m_offset = m_hit ? (addr - tbl_start[found]) : '0;
    end

endmodule

// File: rtl/region_lookup.sv
module region_lookup
    import region_pkg::*;
#(
    parameter int NREG       = 4,
    parameter int AW         = 32,
    parameter int ALIGN_LOG2 = 24,
    localparam int IW        = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [2:0]    cmd_op,
    input  logic [IW-1:0] cmd_idx,
    input  logic [AW-1:0] cmd_start,
    input  logic [AW-1:0] cmd_end,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic [AW-1:0] req_addr,
    input  logic          req_word,
    output logic          resp_valid,
    output logic          resp_hit,
    output logic          resp_fault,
    output logic          resp_multi,
    output logic [IW-1:0] resp_region,
    output logic [AW-1:0] resp_offset
);

    logic [NREG-1:0]         tbl_valid;
    logic [NREG-1:0][AW-1:0] tbl_start;
    logic [NREG-1:0][AW:0]   tbl_end;

    region_table #(.NREG(NREG), .AW(AW), .ALIGN_LOG2(ALIGN_LOG2)) u_table (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_op    (cmd_op),
        .cmd_idx   (cmd_idx),
        .cmd_start (cmd_start),
        .cmd_end   (cmd_end),
        .tbl_valid (tbl_valid),
        .tbl_start (tbl_start),
        .tbl_end   (tbl_end)
    );

    logic [AW-1:0] cap_addr;
    logic          cap_word;
    logic          m_hit, m_fault, m_multi;
    logic [IW-1:0] m_idx;
    logic [AW-1:0] m_offset;

    region_match #(.NREG(NREG), .AW(AW)) u_match (
        .addr      (cap_addr),
        .word      (cap_word),
        .tbl_valid (tbl_valid),
        .tbl_start (tbl_start),
        .tbl_end   (tbl_end),
        .m_hit     (m_hit),
        .m_fault   (m_fault),
        .m_multi   (m_multi),
        .m_idx     (m_idx),
        .m_offset  (m_offset)
    );

    state_e state, state_nx;

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (req_valid) state_nx = ST_CHECK;   // accept
            ST_CHECK: state_nx = ST_RESP;                   // compare
            ST_RESP:  state_nx = ST_IDLE;                   // report
            default:  state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // capture and result registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_addr    <= '0;
            cap_word    <= 1'b0;
            resp_hit    <= 1'b0;
            resp_fault  <= 1'b0;
            resp_multi  <= 1'b0;
            resp_region <= '0;
            resp_offset <= '0;
        end else begin
            if (state == ST_IDLE && req_valid) begin
                cap_addr <= req_addr;
                cap_word <= req_word;
            end
            if (state == ST_CHECK) begin
                resp_hit    <= m_hit;
                resp_fault  <= m_fault;
                resp_multi  <= m_multi;
                resp_region <= m_idx;
                resp_offset <= m_offset;
            end
        end
    end

    // state-decoded outputs
    always_comb begin
        req_ready  = (state == ST_IDLE);
        resp_valid = (state == ST_RESP);
    end

endmodule

// File: rtl/region_lookup_chk.sv
module region_lookup_chk #(
    parameter int NREG = 4,
    parameter int AW   = 32,
    localparam int IW  = $clog2(NREG)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req_valid,
    input logic          req_ready,
    input logic          resp_valid,
    input logic          resp_hit,
    input logic          resp_fault,
    input logic          resp_multi,
    input logic [IW-1:0] resp_region,
    input logic [AW-1:0] resp_offset
);

    assert_one_verdict_R4: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |-> $countones({resp_hit, resp_fault, resp_multi}) == 1);

    assert_nohit_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && !resp_hit) |-> (resp_region == '0 && resp_offset == '0));

    assert_resp_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |=> !resp_valid);

    assert_busy_in_resp_R10: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |-> !req_ready);

    assert_accept_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> (!req_ready && !resp_valid));

    assert_resp_then_ready_R10: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |=> req_ready);

endmodule

bind region_lookup region_lookup_chk #(.NREG(NREG), .AW(AW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .resp_valid  (resp_valid),
    .resp_hit    (resp_hit),
    .resp_fault  (resp_fault),
    .resp_multi  (resp_multi),
    .resp_region (resp_region),
    .resp_offset (resp_offset)
);

// File: tb/region_lookup_bench.sv
`timescale 1ns/1ps
module region_lookup_bench;

    localparam int NREG = 4;
    localparam int AW   = 32;
    localparam int IW   = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [2:0]    cmd_op = 3'd0;
    logic [IW-1:0] cmd_idx = '0;
    logic [AW-1:0] cmd_start = '0;
    logic [AW-1:0] cmd_end = '0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [AW-1:0] req_addr = '0;
    logic          req_word = 1'b0;
    logic          resp_valid, resp_hit, resp_fault, resp_multi;
    logic [IW-1:0] resp_region;
    logic [AW-1:0] resp_offset;

    region_lookup #(.NREG(NREG), .AW(AW), .ALIGN_LOG2(24)) u_region_lookup (
        .clk(clk), .rst_n(rst_n), .cmd_op(cmd_op), .cmd_idx(cmd_idx),
        .cmd_start(cmd_start), .cmd_end(cmd_end), .req_valid(req_valid),
        .req_ready(req_ready), .req_addr(req_addr), .req_word(req_word),
        .resp_valid(resp_valid), .resp_hit(resp_hit), .resp_fault(resp_fault),
        .resp_multi(resp_multi), .resp_region(resp_region), .resp_offset(resp_offset)
    );

    always #2 clk = ~clk;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    // bench-side table model, written from the requirements
    bit          mv [NREG];
    logic [31:0] ms [NREG];
    longint      me [NREG];

    task automatic check(input string tag, input bit ok, input string act, input string exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%s expected=%s", tag, act, exp);
        end
    endtask

    task automatic command(input int op, input int idx, input logic [31:0] s, input logic [31:0] e);
        @(negedge clk);
        cmd_op = 3'(op); cmd_idx = IW'(idx); cmd_start = s; cmd_end = e;
        @(negedge clk);
        cmd_op = 3'd0;
        case (op)
            1: begin mv[idx] = 1; ms[idx] = s; me[idx] = longint'(e); end                    // R6
            2: begin mv[idx] = 1; ms[idx] = s;                                                // R7
                     me[idx] = ((longint'(s) + 1 + 64'h1000000 - 1) / 64'h1000000) * 64'h1000000; end
            3: if (mv[0] && longint'(e) >= me[0]) me[0] = longint'(e);                        // R8
            4: if (mv[1] && longint'(e) >= me[1]) me[1] = longint'(e);                        // R8
            5: mv[idx] = 0;                                                                   // R9
            default: ;
        endcase
    endtask

    // expected result from the model
    task automatic expect_of(input logic [31:0] a, input bit w,
                             output int cnt, output int idx, output logic [31:0] off);
        cnt = 0; idx = 0; off = 0;
        for (int i = 0; i < NREG; i++) begin
            bit m;
            if (w) m = mv[i] && (longint'(a) >= longint'(ms[i])) && (longint'(a) + 4 <= me[i]);
            else   m = mv[i] && (longint'(a) >= longint'(ms[i])) && (longint'(a) < me[i]);
            if (m) begin cnt++; idx = i; off = a - ms[i]; end
        end
        if (cnt != 1) begin idx = 0; off = 0; end
    endtask

    task automatic lookup(input logic [31:0] a, input bit w);
        int cnt, idx; logic [31:0] off;
        string tag;
        bit ok;
        expect_of(a, w, cnt, idx, off);
        @(negedge clk);
        req_valid = 1; req_addr = a; req_word = w;
        @(negedge clk);
        req_valid = 0;
        @(negedge clk);
        if (cnt == 0)      tag = "R4";
        else if (cnt > 1)  tag = "R5";
        else if (w)        tag = "R2/R3";
        else               tag = "R1/R3";
        ok = resp_valid && (resp_hit == (cnt == 1)) && (resp_fault == (cnt == 0)) &&
             (resp_multi == (cnt > 1)) && (resp_region == IW'(idx)) && (resp_offset == off);
        check(tag, ok,
              $sformatf("a=%h w=%0d v%0d h%0d f%0d m%0d r%0d o=%h", a, w, resp_valid,
                        resp_hit, resp_fault, resp_multi, resp_region, resp_offset),
              $sformatf("h%0d f%0d m%0d r%0d o=%h", cnt == 1, cnt == 0, cnt > 1, idx, off));
    endtask

    task automatic sweep();
        for (int i = 0; i < NREG; i++) begin
            if (mv[i]) begin
                longint pts [8];
                pts[0] = longint'(ms[i]) - 1; pts[1] = longint'(ms[i]); pts[2] = longint'(ms[i]) + 1;
                pts[3] = me[i] - 5; pts[4] = me[i] - 4; pts[5] = me[i] - 3;
                pts[6] = me[i] - 1; pts[7] = me[i];
                for (int p = 0; p < 8; p++) begin
                    lookup(pts[p][31:0], 1'b0);
                    lookup(pts[p][31:0], 1'b1);
                end
            end
        end
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            n_fail++; n_checks++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < NREG; i++) begin mv[i] = 0; ms[i] = 0; me[i] = 0; end
        repeat (3) @(negedge clk);
        // R11: reset state
        check("R11", req_ready == 1 && resp_valid == 0,
              $sformatf("ready=%0d valid=%0d", req_ready, resp_valid), "ready=1 valid=0");
        rst_n = 1;
        @(negedge clk);
        lookup(32'h0000_1000, 0);   // R11, R4: empty table faults
        lookup(32'h0000_0000, 1);

        // phase A: code, auto data, stack
        command(1, 0, 32'h0000_1000, 32'h0000_1010);
        command(2, 1, 32'h0020_0000, 32'h0);          // R7: end 0x01000000
        command(1, 2, 32'h0000_3000, 32'h0000_3008);
        sweep();

        // phase B: overlapping region, R5
        command(1, 3, 32'h0000_100C, 32'h0000_2000);
        lookup(32'h0000_100D, 0);                     // R5 multi
        sweep();

        // R9: clear removes it, op 6 does nothing
        command(5, 3, 32'h0, 32'h0);
        command(6, 0, 32'h0, 32'h0);
        lookup(32'h0000_100F, 0);                     // R9: back to unique hit in 0
        lookup(32'h0000_1800, 0);                     // R9: cleared region faults

        // R8: grows
        command(3, 0, 32'h0, 32'h0000_1008);          // below current end: ignored
        lookup(32'h0000_100F, 0);
        lookup(32'h0000_100C, 1);
        command(3, 0, 32'h0, 32'h0000_1020);
        lookup(32'h0000_101F, 0);
        command(4, 1, 32'h0, 32'h0180_0000);
        lookup(32'h017F_FFFC, 1);
        command(4, 1, 32'h0, 32'h0100_0000);          // ignored
        lookup(32'h017F_FFFF, 0);
        command(5, 2, 32'h0, 32'h0);
        command(1, 3, 32'h0000_3000, 32'h0000_3008);
        command(3, 2, 32'h0, 32'hFFFF_FFFF);          // grow code acts on region 0 only
        lookup(32'h0000_3008, 0);
        sweep();

        // phase C: top of address space, R2 and R7
        command(2, 3, 32'hFFFF_FF00, 32'h0);          // end = 2^32
        lookup(32'hFFFF_FFFC, 1);
        lookup(32'hFFFF_FFFF, 0);
        sweep();
        command(1, 3, 32'hFFFF_FF00, 32'hFFFF_FFFF);
        lookup(32'hFFFF_FFFE, 1);                     // R2: wrap must not match
        lookup(32'hFFFF_FFFB, 1);
        sweep();

        // R10: request while busy is ignored
        begin
            int cnt, idx; logic [31:0] off;
            expect_of(32'h0000_1004, 0, cnt, idx, off);
            @(negedge clk);
            req_valid = 1; req_addr = 32'h0000_1004; req_word = 0;
            @(negedge clk);
            check("R10", req_ready == 0 && resp_valid == 0,
                  $sformatf("ready=%0d valid=%0d", req_ready, resp_valid), "ready=0 valid=0");
            req_addr = 32'h0000_3004;                 // driven while busy
            @(negedge clk);
            req_valid = 0;
            check("R10", resp_valid && resp_hit && resp_region == IW'(idx) && resp_offset == off,
                  $sformatf("v%0d h%0d r%0d o=%h", resp_valid, resp_hit, resp_region, resp_offset),
                  $sformatf("v1 h1 r%0d o=%h", idx, off));
            @(negedge clk);
            check("R10", resp_valid == 0 && req_ready == 1,
                  $sformatf("valid=%0d ready=%0d", resp_valid, req_ready), "valid=0 ready=1");
        end

        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

endmodule